// File: doc/BRIEF.md
# Clock Correction Sequence Matcher

This block watches a stream of receive symbols and reports when the most recent symbols spell out a programmed clock correction sequence. A sequence has up to `MAX_SUB` subsequence values. A shared length setting selects how many of them take part. A second, alternate sequence with its own values can be switched on. It uses the same length setting. Each symbol is either a 10-bit raw code or an 8-bit decoded byte with a K-character flag. A mode input chooses how symbols are compared: all ten bits, only the low byte, or the decoded byte together with its K flag.

The match pulse is combinational and appears in the same cycle as the symbol that completes the sequence. It comes with an identifier of the sequence that matched. A downstream elastic buffer also needs to know where the matched sequence begins. For that, every accepted symbol passes through a short window of `MAX_SUB` slots and is then emitted again. The re-emitted symbol carries a start tag when it was the first symbol of a match. The buffer can then insert or delete symbols starting from that tagged symbol.

Top module: `cc_seq_matcher`

## Requirements
- R1: With `cfgWide`=1 and `cfgDecMatch`=0, `matchPulse` rises when the last L accepted symbols equal subsequences 0..L-1 in arrival order, with all ten bits compared. Here L = `cfgLenM1`+1. Subsequence i occupies bits [10i+9:10i] of its configuration word, and subsequence 0 is the oldest symbol.
- R2: With `cfgWide`=0, only bits [7:0] of each symbol and each subsequence are compared. `cfgDecMatch` has no effect in this width.
- R3: With `cfgWide`=1 and `cfgDecMatch`=1, the value {`kFlagIn`, `symIn[7:0]`} is compared with subsequence bits [8:0]. Bit 8 of a subsequence is therefore its K flag, and `symIn[9:8]` and subsequence bit 9 are ignored.
- R4: The alternate sequence (`cfgSeq2`) can match only while `cfgSeq2En`=1. A match of that sequence alone gives `matchSeqId`=1.
- R5: When both sequences match on the same symbol, `matchSeqId`=0. `matchSeqId` is 0 whenever `matchPulse` is 0.
- R6: `matchPulse` is asserted only in a cycle with `symValid`=1, and only once at least L symbols have been accepted since reset. Cycles with `symValid`=0 leave the window untouched.
- R7: Let the n-th accepted symbol be followed by `MAX_SUB` further accepted symbols. After the clock edge that accepts the last of those, `outSym`/`outK` hold symbol n and `outValid` is 1 for that one cycle. At any other time `outValid` is 0 and `outSym`/`outK` hold their values.
- R8: `outStart` is 1 together with a re-emitted symbol exactly when that symbol was the first symbol of some match.
- R9: Reset (`rstN`=0) empties the window, clears the accepted-symbol count and clears all registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symIn | input | 10 | Incoming symbol; in decoded mode bits [7:0] carry the byte |
| kFlagIn | input | 1 | K-character indication from the decoder |
| symValid | input | 1 | Symbol on `symIn` is accepted this cycle |
| cfgSeq1 | input | 40 | Primary sequence, four 10-bit subsequences |
| cfgSeq2 | input | 40 | Alternate sequence, four 10-bit subsequences |
| cfgSeq2En | input | 1 | Enables matching of the alternate sequence |
| cfgLenM1 | input | 2 | Number of subsequences in use, minus one |
| cfgWide | input | 1 | 1: 10-bit compare, 0: low 8 bits only |
| cfgDecMatch | input | 1 | Compare decoded byte plus K flag (only with `cfgWide`=1) |
| matchPulse | output | 1 | A sequence completes with the current symbol |
| matchSeqId | output | 1 | 0: primary sequence, 1: alternate sequence |
| outSym | output | 10 | Re-emitted symbol after the window |
| outK | output | 1 | K flag of the re-emitted symbol |
| outValid | output | 1 | `outSym`/`outK` updated this cycle |
| outStart | output | 1 | Re-emitted symbol is the first symbol of a match |

## Verification
The properties assume that configuration inputs change only while reset is held. They also assume that `symValid` is low throughout reset, because the output register checks refer to the previous cycle's valid strobe. The bench changes the configuration only inside a reset pulse and holds `symValid` low during every reset. It then sweeps all widths, modes and lengths, with the alternate sequence off, distinct, or identical to the primary one. Idle cycles are mixed into the stream, and so are full copies of either sequence, so that matches, overlaps and ties occur in every configuration.

// File: rtl/cc_match_pkg.sv
package cc_match_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic shiftEn;  // accept symbol into window
    logic tagSet;   // mark first symbol of the current match
    logic outEn;    // oldest window slot leaves to output register
  } ccStrobes_t;
endpackage

// File: rtl/cc_match_datapath.sv
module cc_match_datapath
  import cc_match_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int MAX_SUB = 4,
  parameter int LEN_W   = $clog2(MAX_SUB)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SYM_W-1:0]         symIn,
  input  logic                     kFlagIn,
  input  ccStrobes_t               strb,
  input  logic [MAX_SUB*SYM_W-1:0] cfgSeq1,
  input  logic [MAX_SUB*SYM_W-1:0] cfgSeq2,
  input  logic [LEN_W-1:0]         cfgLenM1,
  input  logic                     cfgWide,
  input  logic                     cfgDecMatch,
  output logic                     hit1,
  output logic                     hit2,
  output logic [SYM_W-1:0]         outSym,
  output logic                     outK,
  output logic                     outStart
);
  localparam int SLOT_W = SYM_W + 1;  // K flag on top

  logic [SLOT_W-1:0]  winQ [MAX_SUB];
  logic [SLOT_W-1:0]  slotVal [MAX_SUB];
  logic [MAX_SUB-1:0] tagQ, tagNext;
  logic               decEff;

  assign decEff = cfgDecMatch & cfgWide;

  // slot 0 is the arriving symbol, slot j the one accepted j symbols earlier
  assign slotVal[0] = {kFlagIn, symIn};
  generate
    for (genvar j = 1; j < MAX_SUB; j++) begin : g_slot
      assign slotVal[j] = winQ[j-1];
    end
  endgenerate

  function automatic logic keyEq(input logic [SYM_W-1:0] sub,
                                 input logic [SLOT_W-1:0] slot,
                                 input logic wide, input logic dec);
    if (dec)       keyEq = sub[BYTE_W:0] == {slot[SYM_W], slot[BYTE_W-1:0]};
    else if (wide) keyEq = sub == slot[SYM_W-1:0];
    else           keyEq = sub[BYTE_W-1:0] == slot[BYTE_W-1:0];
  endfunction

  always_comb begin
    hit1 = 1'b1;
    hit2 = 1'b1;
    for (int j = 0; j < MAX_SUB; j++) begin
      if (LEN_W'(j) <= cfgLenM1) begin
        logic [LEN_W-1:0] idx;
        idx = cfgLenM1 - LEN_W'(j);
        if (!keyEq(cfgSeq1[int'(idx)*SYM_W +: SYM_W], slotVal[j], cfgWide, decEff))
          hit1 = 1'b0;
        if (!keyEq(cfgSeq2[int'(idx)*SYM_W +: SYM_W], slotVal[j], cfgWide, decEff))
          hit2 = 1'b0;
      end
    end
  end

  // the first symbol of a match lands in slot cfgLenM1 after the shift
  always_comb begin
    tagNext = {tagQ[MAX_SUB-2:0], 1'b0};
    if (strb.tagSet) tagNext[cfgLenM1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < MAX_SUB; j++) winQ[j] <= '0;
      tagQ     <= '0;
      outSym   <= '0;
      outK     <= 1'b0;
      outStart <= 1'b0;
    end else if (strb.shiftEn) begin
      winQ[0] <= slotVal[0];
      for (int j = 1; j < MAX_SUB; j++) winQ[j] <= winQ[j-1];
      tagQ <= tagNext;
      if (strb.outEn) begin
        outSym   <= winQ[MAX_SUB-1][SYM_W-1:0];
        outK     <= winQ[MAX_SUB-1][SYM_W];
        outStart <= tagQ[MAX_SUB-1];
      end else begin
        outStart <= 1'b0;
      end
    end else begin
      outStart <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_match_ctrl.sv
module cc_match_ctrl
  import cc_match_pkg::*;
#(
  parameter int MAX_SUB = 4,
  parameter int LEN_W   = $clog2(MAX_SUB)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic             hit1,
  input  logic             hit2,
  input  logic             cfgSeq2En,
  input  logic [LEN_W-1:0] cfgLenM1,
  output ccStrobes_t       strb,
  output logic             matchPulse,
  output logic             matchSeqId,
  output logic             outValid
);
  localparam int FILL_W = $clog2(MAX_SUB + 1);

  logic [FILL_W-1:0] fillQ;
  logic              ready, anyHit;

  // the window must already hold L-1 earlier symbols
  assign ready  = fillQ >= FILL_W'(cfgLenM1);
  assign anyHit = symValid & ready & (hit1 | (hit2 & cfgSeq2En));

  assign matchPulse   = anyHit;
  assign matchSeqId   = anyHit & ~hit1;  // primary sequence wins ties
  assign strb.shiftEn = symValid;
  assign strb.tagSet  = anyHit;
  assign strb.outEn   = symValid && (fillQ == FILL_W'(MAX_SUB));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillQ    <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.outEn;
      if (symValid && fillQ != FILL_W'(MAX_SUB)) fillQ <= fillQ + 1'b1;
    end
  end
endmodule

// File: rtl/cc_seq_matcher.sv
module cc_seq_matcher
  import cc_match_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int MAX_SUB = 4,
  localparam int LEN_W  = $clog2(MAX_SUB),
  localparam int CFG_W  = MAX_SUB * SYM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] symIn,
  input  logic             kFlagIn,
  input  logic             symValid,
  input  logic [CFG_W-1:0] cfgSeq1,
  input  logic [CFG_W-1:0] cfgSeq2,
  input  logic             cfgSeq2En,
  input  logic [LEN_W-1:0] cfgLenM1,
  input  logic             cfgWide,
  input  logic             cfgDecMatch,
  output logic             matchPulse,
  output logic             matchSeqId,
  output logic [SYM_W-1:0] outSym,
  output logic             outK,
  output logic             outValid,
  output logic             outStart
);
  ccStrobes_t strb;
  logic       hit1, hit2;

  cc_match_ctrl #(.MAX_SUB(MAX_SUB), .LEN_W(LEN_W)) u_ctrl (
    .clk, .rstN, .symValid, .hit1, .hit2, .cfgSeq2En, .cfgLenM1,
    .strb, .matchPulse, .matchSeqId, .outValid
  );

  cc_match_datapath #(.SYM_W(SYM_W), .MAX_SUB(MAX_SUB), .LEN_W(LEN_W)) u_dp (
    .clk, .rstN, .symIn, .kFlagIn, .strb, .cfgSeq1, .cfgSeq2, .cfgLenM1,
    .cfgWide, .cfgDecMatch, .hit1, .hit2, .outSym, .outK, .outStart
  );
endmodule

// File: rtl/cc_seq_matcher_chk.sv
module cc_seq_matcher_chk #(
  parameter int SYM_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             symValid,
  input logic             cfgSeq2En,
  input logic             matchPulse,
  input logic             matchSeqId,
  input logic [SYM_W-1:0] outSym,
  input logic             outValid,
  input logic             outStart
);
  // R4: alternate identifier only while the alternate sequence is enabled
  p_alt_needs_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && matchSeqId) |-> cfgSeq2En);

  // R5: identifier idles at primary when there is no match
  p_id_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !matchPulse |-> !matchSeqId);

  // R6: no match without an accepted symbol
  p_pulse_needs_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> symValid);

  // R7: an idle cycle leaves the output register alone
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> (!outValid && $stable(outSym)));

  // R7: output valid only after an accepted symbol
  p_out_follows_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(symValid));

  // R8: a start tag only rides on an emitted symbol
  p_start_has_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);
endmodule

bind cc_seq_matcher cc_seq_matcher_chk #(.SYM_W(SYM_W)) u_chk (
  .clk, .rstN, .symValid, .cfgSeq2En, .matchPulse, .matchSeqId,
  .outSym, .outValid, .outStart
);

// File: tb/cc_seq_matcher_tb.sv
module cc_seq_matcher_tb;
  localparam int D = 4;
  localparam int NPUSH = 160;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] symIn = '0;
  logic kFlagIn = 1'b0, symValid = 1'b0;
  logic [39:0] cfgSeq1 = '0, cfgSeq2 = '0;
  logic cfgSeq2En = 1'b0, cfgWide = 1'b1, cfgDecMatch = 1'b0;
  logic [1:0] cfgLenM1 = '0;
  logic matchPulse, matchSeqId, outK, outValid, outStart;
  logic [9:0] outSym;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  cc_seq_matcher u_dut (
    .clk, .rstN, .symIn, .kFlagIn, .symValid, .cfgSeq1, .cfgSeq2, .cfgSeq2En,
    .cfgLenM1, .cfgWide, .cfgDecMatch, .matchPulse, .matchSeqId, .outSym,
    .outK, .outValid, .outStart
  );

  // bench-side history
  logic [9:0] hSym [NPUSH];
  logic       hK   [NPUSH];
  logic       hSt  [NPUSH];
  int         nPush;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic keyEq(input logic [9:0] sub, input logic [9:0] s,
                                 input logic k, input logic wide, input logic dec);
    if (dec && wide) return sub[8:0] == {k, s[7:0]};
    if (wide)        return sub == s;
    return sub[7:0] == s[7:0];
  endfunction

  function automatic logic seqHit(input logic [39:0] cfg, input int n);
    int len = int'(cfgLenM1) + 1;
    if (n < len - 1) return 1'b0;
    for (int i = 0; i < len; i++)
      if (!keyEq(cfg[i*10 +: 10], hSym[n-len+1+i], hK[n-len+1+i], cfgWide, cfgDecMatch))
        return 1'b0;
    return 1'b1;
  endfunction

  function automatic string modeTag();
    if (!cfgWide) return "R2";
    if (cfgDecMatch) return "R3";
    return "R1";
  endfunction

  task automatic doReset();
    @(negedge clk);
    symValid = 1'b0;
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R9", "outValid after reset", outValid, 0);
    chk("R9", "outStart after reset", outStart, 0);
    chk("R9", "outSym after reset", outSym, 0);
    chk("R9", "matchPulse after reset", matchPulse, 0);
    nPush = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    symValid = 1'b0;
    symIn = 10'($urandom);
    kFlagIn = 1'($urandom);
    #1;
    chk("R6", "matchPulse on idle", matchPulse, 0);
    @(posedge clk);
    #1;
    chk("R7", "outValid on idle", outValid, 0);
    chk("R8", "outStart on idle", outStart, 0);
  endtask

  task automatic push(input logic [9:0] s, input logic k);
    logic m1, m2, em, eid;
    int len;
    len = int'(cfgLenM1) + 1;
    @(negedge clk);
    symValid = 1'b1;
    symIn = s;
    kFlagIn = k;
    hSym[nPush] = s;
    hK[nPush] = k;
    hSt[nPush] = 1'b0;
    m1 = seqHit(cfgSeq1, nPush);
    m2 = seqHit(cfgSeq2, nPush) && cfgSeq2En;
    em = m1 || m2;
    eid = !m1 && m2;
    if (em) hSt[nPush-len+1] = 1'b1;
    #1;
    chk(modeTag(), "matchPulse", matchPulse, em);
    chk((m1 && m2) ? "R5" : "R4/R5", "matchSeqId", matchSeqId, eid);
    @(posedge clk);
    #1;
    if (nPush >= D) begin
      chk("R7", "outValid", outValid, 1);
      chk("R7", "outSym", outSym, hSym[nPush-D]);
      chk("R7", "outK", outK, hK[nPush-D]);
      chk("R8", "outStart", outStart, hSt[nPush-D]);
    end else begin
      chk("R6", "outValid while filling", outValid, 0);
    end
    nPush++;
  endtask

  logic [9:0] alph [4] = '{10'h0BC, 10'h2BC, 10'h1BC, 10'h07C};

  task automatic runCfg();
    doReset();
    while (nPush < NPUSH - D) begin
      int r = $urandom_range(0, 15);
      if (r < 3) idle();
      else if (r < 5) begin
        logic [39:0] c = (r == 3) ? cfgSeq1 : cfgSeq2;
        for (int i = 0; i <= int'(cfgLenM1); i++)
          push(c[i*10 +: 10], c[i*10 + 8]);
      end else begin
        push(alph[$urandom_range(0, 3)], 1'($urandom_range(0, 1)));
      end
    end
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    nPush = 0;
    repeat (3) @(posedge clk);
    for (int w = 0; w < 2; w++)
      for (int dm = 0; dm < 2; dm++)
        for (int l = 0; l < 4; l++)
          for (int v = 0; v < 3; v++) begin
            cfgWide = 1'(w);
            cfgDecMatch = 1'(dm);
            cfgLenM1 = 2'(l);
            cfgSeq1 = {10'h0BC, 10'h1BC, 10'h07C, 10'h0BC};
            cfgSeq2 = (v == 2) ? cfgSeq1 : {10'h07C, 10'h0BC, 10'h2BC, 10'h07C};
            cfgSeq2En = (v != 0);
            runCfg();
          end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule